// File: doc/BRIEF.md
# Six-Mode Logarithmic Barrel Shifter

This block moves a data word by any distance from zero to one less than the word width in a single pass. A 3-bit operation code selects one of six operations. Three shift right: logical, arithmetic and rotate. Three shift left: logical, arithmetic and rotate. The shifting datapath is one chain of log2(WIDTH) multiplexer stages. Stage i moves the word right by 2^i places when bit i of the amount is set, and passes it unchanged otherwise. The fill bits that enter from the top are zeros, copies of the sign bit, or the bits that fall off the bottom, depending on the operation.

Left operations use the same right-shifting chain. The word is bit-reversed on the way in and again on the way out. The left arithmetic operation then puts the original most significant bit back in place, so only the lower bits move.

A parameter chooses the output stage. With the output register fitted, the result and a valid flag come out one clock after the request. Without it, the result is combinational and the valid flag passes straight through.

Top module: `bsh_top`

## Requirements
- R1: Operation code 3'b000 (logical right) returns data shifted right by amt, with the top amt bits set to zero.
- R2: Operation code 3'b001 (arithmetic right) shifts right by amt and fills the top amt bits with copies of data bit WIDTH-1.
- R3: Operation code 3'b010 (rotate right) shifts right by amt and moves the low amt input bits into the top amt positions.
- R4: Operation code 3'b100 (logical left) shifts left by amt, with the bottom amt bits set to zero.
- R5: Operation code 3'b101 (arithmetic left) keeps result bit WIDTH-1 equal to input bit WIDTH-1. The lower WIDTH-1 bits equal the lower bits of the input shifted left by amt, with zero fill.
- R6: Operation code 3'b110 (rotate left) shifts left by amt and moves the top amt input bits into the bottom amt positions.
- R7: Operation codes 3'b011 and 3'b111 return the input word unchanged.
- R8: A shift amount of zero returns the input word unchanged under every operation code.
- R9: With the output register fitted (OUT_REG=1), a request presented with vld_i high at one rising edge appears on data_o, with vld_o high, after that edge. vld_o equals vld_i delayed by one clock.
- R10: With the output register fitted, a cycle with vld_i low leaves data_o unchanged.
- R11: While rst_n is low, vld_o and data_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Request valid |
| data_i | input | WIDTH | Word to be shifted |
| amt_i | input | $clog2(WIDTH) | Shift distance |
| op_i | input | 3 | Operation code |
| vld_o | output | 1 | Result valid |
| data_o | output | WIDTH | Shifted result |

## Verification
The bench builds the block with WIDTH=16 and the output register fitted. This gives four multiplexer stages, so every stage and every combination of stages is exercised, and it also covers the one-cycle latency and the hold behaviour.

Random words, amounts and codes, including the two unused codes, are mixed with directed cases:
- the largest amount, 15, on words with the sign bit set and with it clear;
- amount zero under each code;
- alternating patterns that show whether fill bits came from the wrap, the sign or zero.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    typedef enum logic [2:0] {
        OP_SRL = 3'b000,
        OP_SRA = 3'b001,
        OP_ROR = 3'b010,
        OP_SLL = 3'b100,
        OP_SLA = 3'b101,
        OP_ROL = 3'b110
    } bsh_op_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_WRAP = 2'd2
    } bsh_fill_e;

    typedef struct packed {
        logic      flip;
        logic      keep_msb;
        logic      pass;
        bsh_fill_e fill;
    } bsh_ctl_t;

endpackage

// File: rtl/bsh_decode.sv
module bsh_decode
    import bsh_pkg::*;
(
    input  logic [2:0] op_i,
    output bsh_ctl_t   ctl_o
);

    always_comb begin
        ctl_o = '{flip: 1'b0, keep_msb: 1'b0, pass: 1'b0, fill: FILL_ZERO};
        unique case (op_i)
            OP_SRL: ctl_o.fill = FILL_ZERO;
            OP_SRA: ctl_o.fill = FILL_SIGN;
            OP_ROR: ctl_o.fill = FILL_WRAP;
            OP_SLL: ctl_o.flip = 1'b1;
            OP_SLA: begin
                ctl_o.flip     = 1'b1;
                ctl_o.keep_msb = 1'b1;
            end
            OP_ROL: begin
                ctl_o.flip = 1'b1;
                ctl_o.fill = FILL_WRAP;
            end
            default: ctl_o.pass = 1'b1;
        endcase
    end

endmodule

// File: rtl/bsh_reverse.sv
module bsh_reverse #(
    parameter int WIDTH = 16
) (
    input  logic             en_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] data_o
);

    logic [WIDTH-1:0] mirrored;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign mirrored[b] = data_i[WIDTH-1-b];
    end

    assign data_o = en_i ? mirrored : data_i;

endmodule

// File: rtl/bsh_rshift_core.sv
module bsh_rshift_core
    import bsh_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [AMT_W-1:0] amt_i,
    input  bsh_fill_e        fill_i,
    output logic [WIDTH-1:0] data_o
);

    logic [WIDTH-1:0] stage [0:AMT_W];
    logic             sign;

    assign sign     = data_i[WIDTH-1];
    assign stage[0] = data_i;

    for (genvar i = 0; i < AMT_W; i++) begin : g_stage
        localparam int SH = 1 << i;
        logic [SH-1:0]    fill_bits;
        logic [WIDTH-1:0] moved;

        always_comb begin
            unique case (fill_i)
                FILL_WRAP: fill_bits = stage[i][SH-1:0];
                FILL_SIGN: fill_bits = {SH{sign}};
                default:   fill_bits = '0;
            endcase
            moved        = {fill_bits, stage[i][WIDTH-1:SH]};
            stage[i+1]   = amt_i[i] ? moved : stage[i];
        end
    end

    assign data_o = stage[AMT_W];

    // R8: no stage may move the word when the amount is zero
    always_comb begin
        if (amt_i == '0) begin
            a_zero_amt_r8 : assert (data_o == data_i);
        end
    end

endmodule

// File: rtl/bsh_top.sv
module bsh_top
    import bsh_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter bit OUT_REG = 1'b1,
    localparam int AMT_W  = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic [2:0]       op_i,
    output logic             vld_o,
    output logic [WIDTH-1:0] data_o
);

    bsh_ctl_t         ctl;
    logic [WIDTH-1:0] pre;
    logic [WIDTH-1:0] core_out;
    logic [WIDTH-1:0] post;
    logic [WIDTH-1:0] res;

    bsh_decode u_dec (
        .op_i  (op_i),
        .ctl_o (ctl)
    );

    bsh_reverse #(.WIDTH(WIDTH)) u_rev_in (
        .en_i   (ctl.flip),
        .data_i (data_i),
        .data_o (pre)
    );

    bsh_rshift_core #(.WIDTH(WIDTH)) u_core (
        .data_i (pre),
        .amt_i  (amt_i),
        .fill_i (ctl.fill),
        .data_o (core_out)
    );

    bsh_reverse #(.WIDTH(WIDTH)) u_rev_out (
        .en_i   (ctl.flip),
        .data_i (core_out),
        .data_o (post)
    );

    always_comb begin
        if (ctl.pass)          res = data_i;
        else if (ctl.keep_msb) res = {data_i[WIDTH-1], post[WIDTH-2:0]};
        else                   res = post;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_o  <= 1'b0;
                data_o <= '0;
            end else begin
                vld_o <= vld_i;
                if (vld_i) data_o <= res;
            end
        end

        p_vld_rise_r9 : assert property (@(posedge clk) disable iff (!rst_n)
            vld_i |=> vld_o);
        p_vld_low_r9 : assert property (@(posedge clk) disable iff (!rst_n)
            !vld_i |=> !vld_o);
        p_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
            !vld_i |=> $stable(data_o));
    end else begin : g_comb
        assign vld_o  = vld_i;
        assign data_o = res;
    end

    p_srl_top_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SRL && amt_i != '0) |-> !res[WIDTH-1]);
    p_sra_sign_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SRA) |-> res[WIDTH-1] == data_i[WIDTH-1]);
    p_rot_ones_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ROR || op_i == OP_ROL) |-> $countones(res) == $countones(data_i));
    p_sll_low_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SLL && amt_i != '0) |-> !res[0]);

endmodule

// File: tb/sim_bsh_top.sv
module sim_bsh_top;

    localparam int W = 16;
    localparam int A = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vld_i = 1'b0;
    logic [W-1:0] data_i = '0;
    logic [A-1:0] amt_i = '0;
    logic [2:0]   op_i = '0;
    logic         vld_o;
    logic [W-1:0] data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bsh_top #(.WIDTH(W), .OUT_REG(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .data_i(data_i),
        .amt_i(amt_i), .op_i(op_i), .vld_o(vld_o), .data_o(data_o)
    );

    function automatic logic [W-1:0] model(logic [W-1:0] d, int s, logic [2:0] op);
        logic [W-1:0] a, b;
        if (s == 0) return d;
        case (op)
            3'b000: return d >> s;
            3'b001: return W'($signed(d) >>> s);
            3'b010: begin a = d >> s; b = d << (W - s); return a | b; end
            3'b100: return d << s;
            3'b101: begin a = d << s; return {d[W-1], a[W-2:0]}; end
            3'b110: begin a = d << s; b = d >> (W - s); return a | b; end
            default: return d;
        endcase
    endfunction

    function automatic string tag(logic [2:0] op, int s);
        if (s == 0) return "R8";
        case (op)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b100: return "R4";
            3'b101: return "R5";
            3'b110: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [W-1:0] d, int s, logic [2:0] op);
        logic [W-1:0] exp;
        exp = model(d, s, op);
        @(negedge clk);
        vld_i = 1'b1; data_i = d; amt_i = A'(s); op_i = op;
        @(negedge clk);
        vld_i = 1'b0;
        check(data_o == exp, tag(op, s), data_o, exp);
        check(vld_o == 1'b1, "R9", W'(vld_o), W'(1));
    endtask

    initial begin
        logic [W-1:0] held;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(vld_o == 1'b0 && data_o == '0, "R11", data_o, '0);
        rst_n = 1'b1;

        // directed corner cases
        apply(16'h8001, 15, 3'b000);   // R1
        apply(16'h8000, 15, 3'b001);   // R2
        apply(16'h4000, 15, 3'b001);   // R2
        apply(16'h00F1, 4, 3'b010);    // R3
        apply(16'hFFFF, 15, 3'b100);   // R4
        apply(16'hC003, 1, 3'b101);    // R5
        apply(16'h7FFF, 15, 3'b101);   // R5
        apply(16'hA5C3, 7, 3'b110);    // R6
        apply(16'h1234, 9, 3'b011);    // R7
        apply(16'hBEEF, 3, 3'b111);    // R7
        for (int op = 0; op < 8; op++) apply(16'hA5A5, 0, 3'(op)); // R8

        // R10: vld_i low must not disturb data_o
        apply(16'h0F0F, 2, 3'b100);
        held = data_o;
        @(negedge clk);
        data_i = 16'hFFFF; amt_i = 4'd5; op_i = 3'b010;
        @(negedge clk);
        check(data_o == held, "R10", data_o, held);
        check(vld_o == 1'b0, "R9", W'(vld_o), '0);

        // constrained random
        for (int n = 0; n < 400; n++) begin
            apply(W'($urandom), int'($urandom_range(0, W - 1)), 3'($urandom_range(0, 7)));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule